// File: doc/BRIEF.md
# Carry-Skip Adder/Subtractor

This block combines two N-bit unsigned operands into an N-bit result in a single combinational path. There is no clock and no reset. The operands are cut into N/M groups of M bits. Inside each group a ripple chain of full adders forms the sum bits. The group's outgoing carry comes from a two-way selector. When every bit position of the group would pass a carry through, the selector forwards the group's incoming carry straight to the next group. Otherwise it forwards the carry that comes out of the ripple chain. In the worst case a carry then crosses whole groups through one selector each, and does not have to ripple through every bit.

A mode input switches the same datapath to subtraction. Each bit of the second operand is inverted and a carry of one enters the lowest group, so the result is the first operand minus the second in two's complement. A single flag output carries the final carry out of the top group. In add mode it is the unsigned carry. In subtract mode it is high when no borrow happened. The width N and the group size M are parameters, and N must be a whole multiple of M.

Top module: `csk_addsub`

## Requirements
- R1: With mode_sub_i = 0, res_o equals (opa_i + opb_i) modulo 2^N for every pair of operands.
- R2: With mode_sub_i = 1, res_o equals (opa_i - opb_i) modulo 2^N, in two's complement, for every pair of operands.
- R3: With mode_sub_i = 0, flag_o is bit N of the (N+1)-bit unsigned sum opa_i + opb_i, which is the carry out of the most significant bit.
- R4: With mode_sub_i = 1, flag_o is 1 exactly when opa_i >= opb_i as unsigned numbers, which means no borrow occurred.
- R5: A group whose M per-bit propagate terms (opa bit XOR conditioned opb bit) are all 1 hands its incoming carry unchanged to the next group. Any other group hands on its own ripple carry-out. Seen at the ports, FFFF + 0001 gives 0000 with flag 1, and 1234 - 1234 gives 0000 with flag 1.
- R6: For N = 4 in add mode, 0000 + 0001 gives 0001 with flag 0, and 1111 + 1110 gives 1101 with flag 1.
- R7: R1 to R4 hold for every legal parameter pair. A split with N not a multiple of M is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | N | First operand (minuend in subtract mode) |
| opb_i | input | N | Second operand (subtrahend in subtract mode) |
| mode_sub_i | input | 1 | 0 = add, 1 = subtract |
| res_o | output | N | Sum or difference modulo 2^N |
| flag_o | output | 1 | Final carry out: carry in add mode, no-borrow in subtract mode |

## Verification
A 4-bit instance with 2-bit groups is driven with every operand pair in both modes, so every pattern of per-group propagate, skip and generate is reached at that size. A 16-bit instance with 4-bit groups takes a table of directed vectors. These pick out long skip runs: an all-propagate operand pair with a carry entering at the bottom, equal operands under subtraction, and a carry generated in the lowest group that must cross three skipping groups. They also pick out wrap to zero and top-bit carries. The same instance then takes pseudo-random vectors in both modes, and these separate a correct skip selector from one with swapped inputs or a wrong propagate term, because those faults only show when a group does or does not fully propagate.

// File: rtl/csk_pkg.sv
package csk_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } csk_op_e;

endpackage

// File: rtl/csk_operand_cond.sv
module csk_operand_cond #(
    parameter int N = 16
) (
    input  logic [N-1:0]      opb_i,
    input  csk_pkg::csk_op_e  mode_i,
    output logic [N-1:0]      opb_eff_o,
    output logic              cin_o
);
    import csk_pkg::*;

    always_comb begin
        unique case (mode_i)
            OP_ADD: begin
                opb_eff_o = opb_i;
                cin_o     = 1'b0;
            end
            OP_SUB: begin
                opb_eff_o = ~opb_i;
                cin_o     = 1'b1;
            end
            default: begin
                opb_eff_o = opb_i;
                cin_o     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/csk_skip_mux.sv
module csk_skip_mux (
    input  logic sel_skip_i,
    input  logic skip_i,
    input  logic ripple_i,
    output logic y_o
);

    assign y_o = sel_skip_i ? skip_i : ripple_i;

endmodule

// File: rtl/csk_ripple_group.sv
module csk_ripple_group #(
    parameter int M = 4
) (
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    input  logic         cin_i,
    output logic [M-1:0] sum_o,
    output logic         cout_o,
    output logic         prop_o
);

    logic [M:0]   chain;
    logic [M-1:0] pbit;
    logic [M-1:0] gbit;

    assign chain[0] = cin_i;

    for (genvar k = 0; k < M; k++) begin : g_bit
        assign pbit[k]    = a_i[k] ^ b_i[k];
        assign gbit[k]    = a_i[k] & b_i[k];
        assign sum_o[k]   = pbit[k] ^ chain[k];
        assign chain[k+1] = gbit[k] | (pbit[k] & chain[k]);
    end

    assign prop_o = &pbit;

    csk_skip_mux u_skip (
        .sel_skip_i (prop_o),
        .skip_i     (cin_i),
        .ripple_i   (chain[M]),
        .y_o        (cout_o)
    );

    // R5: bypass must agree with the ripple chain it replaces
    always_comb begin
        a_r5_skip_equals_ripple: assert (cout_o == chain[M]);
        if (prop_o) begin
            a_r5_propagate_forwards_cin: assert (cout_o == cin_i);
        end
    end

endmodule

// File: rtl/csk_addsub.sv
module csk_addsub #(
    parameter int N = 16,
    parameter int M = 4
) (
    input  logic [N-1:0] opa_i,
    input  logic [N-1:0] opb_i,
    input  logic         mode_sub_i,
    output logic [N-1:0] res_o,
    output logic         flag_o
);
    import csk_pkg::*;

    localparam int P = N / M;

    // R7: illegal split is rejected while elaborating
    if (N % M != 0) begin : g_bad_split
        $error("csk_addsub: N must be a multiple of M");
    end

    csk_op_e      mode;
    logic [N-1:0] opb_eff;
    logic [P:0]   gcar;

    assign mode = csk_op_e'(mode_sub_i);

    csk_operand_cond #(.N(N)) u_cond (
        .opb_i     (opb_i),
        .mode_i    (mode),
        .opb_eff_o (opb_eff),
        .cin_o     (gcar[0])
    );

    for (genvar g = 0; g < P; g++) begin : g_grp
        logic gprop;
        csk_ripple_group #(.M(M)) u_grp (
            .a_i    (opa_i[g*M +: M]),
            .b_i    (opb_eff[g*M +: M]),
            .cin_i  (gcar[g]),
            .sum_o  (res_o[g*M +: M]),
            .cout_o (gcar[g+1]),
            .prop_o (gprop)
        );
    end

    assign flag_o = gcar[P];

    // Arithmetic cross-check against the language operators
    logic [N:0]   chk_sum;
    logic [N-1:0] chk_dif;
    assign chk_sum = {1'b0, opa_i} + {1'b0, opb_i};
    assign chk_dif = opa_i - opb_i;

    always_comb begin
        if (mode == OP_ADD) begin
            a_r1_add_result: assert (res_o == chk_sum[N-1:0]);
            a_r3_add_carry:  assert (flag_o == chk_sum[N]);
        end else begin
            a_r2_sub_result: assert (res_o == chk_dif);
            a_r4_no_borrow:  assert (flag_o == (opa_i >= opb_i));
        end
    end

endmodule

// File: tb/test_csk_addsub.sv
module test_csk_addsub;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_N     = 2000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // wide instance: N=16, M=4
    logic [15:0] wa, wb, wres;
    logic        wsub, wflag;
    // narrow instance: N=4, M=2
    logic [3:0]  na, nb, nres;
    logic        nsub, nflag;

    csk_addsub #(.N(16), .M(4)) i_csk_addsub (
        .opa_i (wa), .opb_i (wb), .mode_sub_i (wsub),
        .res_o (wres), .flag_o (wflag)
    );

    csk_addsub #(.N(4), .M(2)) i_csk_addsub_n4 (
        .opa_i (na), .opb_i (nb), .mode_sub_i (nsub),
        .res_o (nres), .flag_o (nflag)
    );

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got flag/res %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_w(input logic s, input logic [15:0] a, input logic [15:0] b);
        @(posedge clk);
        wsub = s; wa = a; wb = b;
        @(negedge clk);
    endtask

    task automatic drive_n(input logic s, input logic [3:0] a, input logic [3:0] b);
        @(posedge clk);
        nsub = s; na = a; nb = b;
        @(negedge clk);
    endtask

    // {sub, a, b, flag, res}
    localparam logic [49:0] VECS [10] = '{
        {1'b0, 16'h0000, 16'h0001, 1'b0, 16'h0001},
        {1'b0, 16'hFFFF, 16'h0001, 1'b1, 16'h0000},
        {1'b0, 16'hFFFF, 16'h0000, 1'b0, 16'hFFFF},
        {1'b1, 16'h1234, 16'h1234, 1'b1, 16'h0000},
        {1'b1, 16'h0000, 16'h0001, 1'b0, 16'hFFFF},
        {1'b0, 16'h8000, 16'h8000, 1'b1, 16'h0000},
        {1'b0, 16'h0F0F, 16'h00F1, 1'b0, 16'h1000},
        {1'b1, 16'h5000, 16'h3001, 1'b1, 16'h1FFF},
        {1'b0, 16'h7FFF, 16'h0001, 1'b0, 16'h8000},
        {1'b1, 16'h0001, 16'hFFFF, 1'b0, 16'h0002}
    };

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        wa = '0; wb = '0; wsub = 1'b0;
        na = '0; nb = '0; nsub = 1'b0;

        // idle state: all-zero inputs give zero, no carry (R1, R3)
        @(negedge clk);
        check("R1 idle", {wflag, wres}, 17'h0);
        check("R3 idle", {12'h0, nflag, nres}, 17'h0);

        // directed table, R5 skip runs included
        for (int i = 0; i < 10; i++) begin
            drive_w(VECS[i][49], VECS[i][48:33], VECS[i][32:17]);
            check(VECS[i][49] ? "R2/R4/R5 table" : "R1/R3/R5 table",
                  {wflag, wres}, VECS[i][16:0]);
        end

        // R6 reference cases for N=4
        drive_n(1'b0, 4'b0000, 4'b0001);
        check("R6 0000+0001", {12'h0, nflag, nres}, {12'h0, 1'b0, 4'b0001});
        drive_n(1'b0, 4'b1111, 4'b1110);
        check("R6 1111+1110", {12'h0, nflag, nres}, {12'h0, 1'b1, 4'b1101});

        // R7: exhaustive at N=4, M=2
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [4:0] e;
                    drive_n(s[0], a[3:0], b[3:0]);
                    if (s == 0) begin
                        e = {1'b0, a[3:0]} + {1'b0, b[3:0]};
                        check("R1/R3/R7 n4 add", {12'h0, nflag, nres}, {12'h0, e});
                    end else begin
                        e[3:0] = a[3:0] - b[3:0];
                        e[4]   = (a >= b);
                        check("R2/R4/R7 n4 sub", {12'h0, nflag, nres}, {12'h0, e});
                    end
                end
            end
        end

        // random at N=16, M=4, both modes
        void'($urandom(32'd7));
        for (int i = 0; i < RAND_N; i++) begin
            logic [15:0] ra, rb;
            logic [16:0] e;
            logic        rs;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rs = i[0];
            drive_w(rs, ra, rb);
            if (!rs) begin
                e = {1'b0, ra} + {1'b0, rb};
                check("R1/R3 random add", {wflag, wres}, e);
            end else begin
                e[15:0] = ra - rb;
                e[16]   = (ra >= rb);
                check("R2/R4 random sub", {wflag, wres}, e);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule